// File: doc/BRIEF.md
# Dual-Direction Latching Bus Transceiver

This block passes data between two parallel ports, A and B, in both directions at once. Each direction has its own storage word and its own three controls: a latch enable, a storage clock and an output enable. The storage word follows its input while the latch enable is high. It keeps its value while the latch enable is low and the storage clock does not move. It takes a new input value when the storage clock falls while the latch enable is low. Data is carried without inversion.

All control pins are sampled by a fast system clock, which keeps the block fully synchronous. A falling storage clock is recognised when the sample taken at one system-clock edge is high and the sample at the next edge is low. Each port presents its value and its drive enable as two separate outputs rather than a bidirectional pin, so the surrounding logic or pad ring builds the tri-state. The B-side drive enable is active high. The A-side drive enable is active low. The enables only gate the drive: data captured while a port is not driven is shown as soon as drive returns.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A synchronous active-high reset clears both storage words to zero, so `b_out` and `a_out` read zero after the first system-clock edge with `rst` high.
- R2: While `ab_le` is 1 at a system-clock edge, `b_out` takes the value of `a_in` sampled at that edge, unchanged and not inverted.
- R3: While `ab_le` is 0 and `ab_clk` is sampled at the same level at two consecutive edges, `b_out` keeps its value.
- R4: While `ab_le` is 0, an edge where `ab_clk` is sampled 0 after having been sampled 1 at the previous edge loads `a_in` into the A-to-B storage word.
- R5: `b_drive` equals `ab_oe` (1 = port B driven, 0 = port B high-impedance).
- R6: The B-to-A storage word obeys the same rules as R2 to R4, using `ba_le`, `ba_clk` and `b_in`, and is shown on `a_out`.
- R7: `a_drive` equals the inverse of `ba_oe_n` (0 on `ba_oe_n` = port A driven).
- R8: The output enables never change the stored words. Values loaded while a port is not driven are present on its value output, and are seen when drive is enabled again.
- R9: The two directions are independent. Each one can be in a different mode in the same cycle without affecting the other.
- R10: A rising storage clock with the latch enable low loads nothing. Transparency has priority over a falling storage clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all controls |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Data arriving on port A |
| b_in | input | 18 | Data arriving on port B |
| ab_le | input | 1 | A-to-B latch enable, high = transparent |
| ab_clk | input | 1 | A-to-B storage clock, falling edge loads |
| ab_oe | input | 1 | Port B drive enable, active high |
| ba_le | input | 1 | B-to-A latch enable, high = transparent |
| ba_clk | input | 1 | B-to-A storage clock, falling edge loads |
| ba_oe_n | input | 1 | Port A drive enable, active low |
| b_out | output | 18 | Value presented on port B |
| b_drive | output | 1 | Port B driven when 1 |
| a_out | output | 18 | Value presented on port A |
| a_drive | output | 1 | Port A driven when 1 |

## Verification
Two things can fall in the same system-clock cycle. One is a load in one direction while the other direction holds or is transparent. The other is a falling storage clock that arrives while the latch enable is still high, where transparency must win. The bench provokes both with directed steps and then with long random runs that toggle all six controls at once. A behavioural model updated at every clock edge gives the expected word and enable for each port. Every mismatch is reported with the mode the model was in when it made its prediction.

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             ab_le,
  input  logic             ab_clk,
  input  logic             ab_oe,
  input  logic             ba_le,
  input  logic             ba_clk,
  input  logic             ba_oe_n,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drive,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drive
);

  logic             ab_clk_q, ba_clk_q;
  logic             ab_fall, ba_fall;
  logic [WIDTH-1:0] ab_word, ba_word;

  always_ff @(posedge clk) begin
    ab_clk_q <= ab_clk;
    ba_clk_q <= ba_clk;
  end

  assign ab_fall = ab_clk_q & ~ab_clk;
  assign ba_fall = ba_clk_q & ~ba_clk;

  always_ff @(posedge clk) begin
    if (rst)                    ab_word <= '0;
    else if (ab_le || ab_fall)  ab_word <= a_in;
  end

  always_ff @(posedge clk) begin
    if (rst)                    ba_word <= '0;
    else if (ba_le || ba_fall)  ba_word <= b_in;
  end

  assign b_out   = ab_word;
  assign a_out   = ba_word;
  assign b_drive = ab_oe;
  assign a_drive = ~ba_oe_n;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (b_out == '0 && a_out == '0));

  a_r2_transparent_ab: assert property (@(posedge clk) disable iff (rst)
    ab_le |=> b_out == $past(a_in));

  a_r3_hold_ab: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && !$fell(ab_clk)) |=> $stable(b_out));

  a_r4_capture_ab: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && $fell(ab_clk)) |=> b_out == $past(a_in));

  a_r6_transparent_ba: assert property (@(posedge clk) disable iff (rst)
    ba_le |=> a_out == $past(b_in));

  a_r6_hold_ba: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && !$fell(ba_clk)) |=> $stable(a_out));

  a_r6_capture_ba: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && $fell(ba_clk)) |=> a_out == $past(b_in));

endmodule

// File: tb/tb_bus_xcvr_reg.sv
module tb_bus_xcvr_reg;
  localparam int W = 18;

  logic clk = 0;
  logic rst = 1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_le = 0, ab_clk = 0, ab_oe = 0, ba_le = 0, ba_clk = 0, ba_oe_n = 1;
  logic [W-1:0] b_out, a_out;
  logic b_drive, a_drive;

  int total = 0, bad = 0;
  bit done = 0;

  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic m_ab_prev = 0, m_ba_prev = 0;
  string t_ab = "R1", t_ba = "R1";

  always #5 clk = ~clk;

  bus_xcvr_reg #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive));

  always @(posedge clk) begin
    if (rst) begin
      m_ab = '0; m_ba = '0; t_ab = "R1"; t_ba = "R1";
    end else begin
      if (ab_le) begin m_ab = a_in; t_ab = (m_ab_prev && !ab_clk) ? "R10" : "R2"; end
      else if (m_ab_prev && !ab_clk) begin m_ab = a_in; t_ab = "R4"; end
      else t_ab = (!m_ab_prev && ab_clk) ? "R10" : "R3";
      if (ba_le) begin m_ba = b_in; t_ba = (m_ba_prev && !ba_clk) ? "R10" : "R6"; end
      else if (m_ba_prev && !ba_clk) begin m_ba = b_in; t_ba = "R6"; end
      else t_ba = (!m_ba_prev && ba_clk) ? "R10" : "R6";
    end
    m_ab_prev = ab_clk;
    m_ba_prev = ba_clk;
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk({t_ab, " b_out R9"}, b_out, m_ab);
      chk({t_ba, " a_out R9"}, a_out, m_ba);
      chk("R5 b_drive", {{(W-1){1'b0}}, b_drive}, {{(W-1){1'b0}}, ab_oe});
      chk("R7 a_drive", {{(W-1){1'b0}}, a_drive}, {{(W-1){1'b0}}, !ba_oe_n});
    end
  end

  task automatic step(input logic ale, input logic ack, input logic aoe,
                      input logic ble, input logic bck, input logic boen,
                      input logic [W-1:0] a, input logic [W-1:0] b);
    @(posedge clk); #2;
    ab_le = ale; ab_clk = ack; ab_oe = aoe;
    ba_le = ble; ba_clk = bck; ba_oe_n = boen;
    a_in = a; b_in = b;
  endtask

  task automatic finish_up();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    step(0,0,0, 0,0,1, 18'h3FFFF, 18'h2AAAA);
    step(0,0,0, 0,0,1, 18'h3FFFF, 18'h2AAAA);
    @(posedge clk); #2; rst = 0;
    // R1 reset zero observed; R2 transparent with true data, drive both off
    step(1,0,0, 0,0,1, 18'h12345, 18'h0);
    step(1,0,1, 0,0,1, 18'h2F0F0, 18'h0);
    // R3 hold with steady clock, R10 rising edge ignored
    step(0,0,1, 0,0,1, 18'h11111, 18'h0);
    step(0,1,1, 0,0,1, 18'h22222, 18'h0);
    step(0,1,1, 0,0,1, 18'h33333, 18'h0);
    // R4 falling edge loads
    step(0,0,1, 0,0,1, 18'h0ABCD, 18'h0);
    step(0,0,1, 0,0,1, 18'h3C3C3, 18'h0);
    // R6 B-to-A modes, R7 active-low enable, R9 A-to-B holds meanwhile
    step(0,0,1, 1,1,0, 18'h0, 18'h15555);
    step(0,0,1, 0,1,0, 18'h0, 18'h0F00F);
    step(0,0,1, 0,0,0, 18'h0, 18'h30303);
    step(0,0,1, 0,0,1, 18'h0, 18'h00001);
    // R8 load while disabled, then enable
    step(0,1,0, 0,1,1, 18'h1BEEF, 18'h2CAFE);
    step(0,0,0, 0,0,1, 18'h1BEEF, 18'h2CAFE);
    step(0,0,1, 0,0,0, 18'h0, 18'h0);
    // R10 falling edge during transparency; R9 opposite modes same cycle
    step(1,1,1, 0,1,0, 18'h01010, 18'h02020);
    step(1,0,1, 0,0,0, 18'h04040, 18'h08080);
    step(0,0,1, 1,0,0, 18'h10101, 18'h20202);
    // R1 reset mid-run
    @(posedge clk); #2; rst = 1;
    @(posedge clk); #2; rst = 0;
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0,3) == 0, $urandom_range(0,1), $urandom_range(0,1),
           $urandom_range(0,3) == 0, $urandom_range(0,1), $urandom_range(0,1),
           W'($urandom), W'($urandom));
    @(posedge clk); @(negedge clk); #1;
    finish_up();
  end
endmodule